// File: doc/BRIEF.md
# Long-Mode Segmented Linear Address Generator

This block forms the linear address of a memory access under 64-bit mode segmentation. A segment selector picks one of six segment registers, and the block adds a base to a 64-bit effective offset only where that mode requires one. Four of the segments are flat and use a base of zero. The two thread-pointer segments take their base from dedicated 64-bit base registers.

No limit is ever enforced. The only fault is a non-canonical result, meaning the top seventeen bits of the sum are not all equal (48-bit virtual addressing).

Each segment keeps a 32-bit base and a 20-bit limit. These are loaded through a descriptor-load port and stay available for 32-bit compatibility semantics. A descriptor load into either thread-pointer segment also refreshes that segment's wide base register with the zero-extended descriptor base. Software can also write the wide base registers directly. The address path is purely combinational. All state updates on the clock edge.

Top module: `lm_linaddr_gen`

## Requirements
- R1: When `seg_sel` is 0, 1, 2 or 3 (the four flat segments), `lin_addr` equals `ofs`, whatever base was loaded into that segment.
- R2: When `seg_sel` is 4 or 5, `lin_addr` is `ofs` plus the 64-bit base register of segment 4 or 5 respectively, modulo 2^64.
- R3: No limit check is made: an offset above a segment's cached limit raises no fault if the result is canonical.
- R4: `canon_fault` is 1 exactly when bits 63 to 47 of `lin_addr` are not all equal. It is combinational with `lin_addr`.
- R5: A descriptor load (`ld_en`=1) with `ld_seg` of 4 or 5 sets that segment's 64-bit base register to `ld_base` zero-extended. The new base is visible from the cycle after the clock edge.
- R6: `wr_fs`=1 (or `wr_gs`=1) writes `wr_data` into the 64-bit base register of segment 4 (or 5). The new base is visible from the cycle after the clock edge.
- R7: When a descriptor load and a direct write target the same wide base register in the same cycle, the descriptor load wins.
- R8: Every descriptor load with `ld_seg` below 6 caches `ld_base` and `ld_limit` for that segment. These show on `desc_base` and `desc_limit` while `seg_sel` selects the segment.
- R9: A synchronous reset (`rst`=1 at a clock edge) clears both wide base registers and all cached bases and limits to zero.
- R10: `seg_sel` values 6 and 7 behave as flat segments, with `desc_base` and `desc_limit` at zero. A descriptor load with `ld_seg` of 6 or 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_sel | input | 3 | Segment used by the access (0..3 flat, 4 and 5 thread-pointer) |
| ofs | input | 64 | Effective address offset |
| wr_fs | input | 1 | Direct write strobe for the segment 4 wide base |
| wr_gs | input | 1 | Direct write strobe for the segment 5 wide base |
| wr_data | input | 64 | Data for the direct base writes |
| ld_en | input | 1 | Descriptor load strobe |
| ld_seg | input | 3 | Segment targeted by the descriptor load |
| ld_base | input | 32 | Base field of the loaded descriptor |
| ld_limit | input | 20 | Limit field of the loaded descriptor |
| lin_addr | output | 64 | Linear address |
| canon_fault | output | 1 | Non-canonical linear address |
| desc_base | output | 32 | Cached descriptor base of the selected segment |
| desc_limit | output | 20 | Cached descriptor limit of the selected segment |

## Verification
The assertions check several properties on every cycle:
- flat segments pass the offset through unchanged (R1);
- the fault flag tracks the sign-extension test of the result (R4);
- a descriptor load or a direct write into a wide base shows up in the next cycle's sum, with the load taking precedence (R5, R6, R7).

Some behaviours need the bench's scenarios:
- the reset clearing of all state (R9);
- the descriptor cache read-back (R8);
- limits being ignored (R3);
- the fault boundaries exactly at the canonical edges (R4).

// File: rtl/lm_linaddr_gen.sv
module lm_linaddr_gen #(
  parameter int ADDR_W  = 64,
  parameter int VA_W    = 48,
  parameter int DBASE_W = 32,
  parameter int DLIM_W  = 20,
  parameter int SEL_W   = 3,
  parameter int NSEG    = 6,
  parameter int FS_IDX  = 4,
  parameter int GS_IDX  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   seg_sel,
  input  logic [ADDR_W-1:0]  ofs,
  input  logic               wr_fs,
  input  logic               wr_gs,
  input  logic [ADDR_W-1:0]  wr_data,
  input  logic               ld_en,
  input  logic [SEL_W-1:0]   ld_seg,
  input  logic [DBASE_W-1:0] ld_base,
  input  logic [DLIM_W-1:0]  ld_limit,
  output logic [ADDR_W-1:0]  lin_addr,
  output logic               canon_fault,
  output logic [DBASE_W-1:0] desc_base,
  output logic [DLIM_W-1:0]  desc_limit
);
  localparam int HI_W = ADDR_W - VA_W + 1;

  logic [DBASE_W-1:0] dbase_q [NSEG];
  logic [DLIM_W-1:0]  dlim_q  [NSEG];
  logic [ADDR_W-1:0]  wide_q  [2];
  logic [ADDR_W-1:0]  eff_base;
  logic [HI_W-1:0]    hi_bits;

  for (genvar g = 0; g < NSEG; g++) begin : g_desc
    always_ff @(posedge clk) begin
      if (rst) begin
        dbase_q[g] <= '0;
        dlim_q[g]  <= '0;
      end else if (ld_en && ld_seg == SEL_W'(g)) begin
        dbase_q[g] <= ld_base;
        dlim_q[g]  <= ld_limit;
      end
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_wide
    localparam int IDX = (w == 0) ? FS_IDX : GS_IDX;
    logic we;
    assign we = (w == 0) ? wr_fs : wr_gs;
    always_ff @(posedge clk) begin
      if (rst)
        wide_q[w] <= '0;
      else if (ld_en && ld_seg == SEL_W'(IDX))
        wide_q[w] <= ADDR_W'(ld_base);
      else if (we)
        wide_q[w] <= wr_data;
    end
  end

  always_comb begin
    eff_base = '0;
    if (seg_sel == SEL_W'(FS_IDX)) eff_base = wide_q[0];
    if (seg_sel == SEL_W'(GS_IDX)) eff_base = wide_q[1];
  end

  assign lin_addr    = ofs + eff_base;
  assign hi_bits     = lin_addr[ADDR_W-1:VA_W-1];
  assign canon_fault = !((&hi_bits) || !(|hi_bits));

  always_comb begin
    desc_base  = '0;
    desc_limit = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (seg_sel == SEL_W'(i)) begin
        desc_base  = dbase_q[i];
        desc_limit = dlim_q[i];
      end
    end
  end
endmodule

// File: rtl/lm_linaddr_gen_chk.sv
module lm_linaddr_gen_chk #(
  parameter int ADDR_W  = 64,
  parameter int VA_W    = 48,
  parameter int DBASE_W = 32,
  parameter int SEL_W   = 3,
  parameter int FS_IDX  = 4,
  parameter int GS_IDX  = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [SEL_W-1:0]   seg_sel,
  input logic [ADDR_W-1:0]  ofs,
  input logic               wr_fs,
  input logic               wr_gs,
  input logic [ADDR_W-1:0]  wr_data,
  input logic               ld_en,
  input logic [SEL_W-1:0]   ld_seg,
  input logic [DBASE_W-1:0] ld_base,
  input logic [ADDR_W-1:0]  lin_addr,
  input logic               canon_fault
);
  localparam int HI_W = ADDR_W - VA_W + 1;
  localparam logic [SEL_W-1:0] FS = SEL_W'(FS_IDX);
  localparam logic [SEL_W-1:0] GS = SEL_W'(GS_IDX);

  a_r1_flat_segments: assert property (@(posedge clk) disable iff (rst)
    (seg_sel != FS && seg_sel != GS) |-> lin_addr == ofs);

  a_r4_canonical_flag: assert property (@(posedge clk) disable iff (rst)
    canon_fault == !($countones(lin_addr[ADDR_W-1:VA_W-1]) == 0 ||
                     $countones(lin_addr[ADDR_W-1:VA_W-1]) == HI_W));

  a_r5_desc_load_base: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_seg == FS) |=>
      (seg_sel != FS || lin_addr == ofs + ADDR_W'($past(ld_base))));

  a_r6_direct_write: assert property (@(posedge clk) disable iff (rst)
    (wr_fs && !(ld_en && ld_seg == FS)) |=>
      (seg_sel != FS || lin_addr == ofs + $past(wr_data)));

  a_r7_load_priority: assert property (@(posedge clk) disable iff (rst)
    (wr_gs && ld_en && ld_seg == GS) |=>
      (seg_sel != GS || lin_addr == ofs + ADDR_W'($past(ld_base))));

  unused_wr_gs_path: assert property (@(posedge clk) disable iff (rst)
    (wr_gs && !(ld_en && ld_seg == GS)) |=>
      (seg_sel != GS || lin_addr == ofs + $past(wr_data)));
endmodule

bind lm_linaddr_gen lm_linaddr_gen_chk #(
  .ADDR_W(ADDR_W), .VA_W(VA_W), .DBASE_W(DBASE_W),
  .SEL_W(SEL_W), .FS_IDX(FS_IDX), .GS_IDX(GS_IDX)
) chk (.*);

// File: tb/lm_linaddr_gen_test.sv
`timescale 1ns/1ps
module lm_linaddr_gen_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [2:0]  seg_sel = 0;
  logic [63:0] ofs = 0;
  logic        wr_fs = 0, wr_gs = 0;
  logic [63:0] wr_data = 0;
  logic        ld_en = 0;
  logic [2:0]  ld_seg = 0;
  logic [31:0] ld_base = 0;
  logic [19:0] ld_limit = 0;
  logic [63:0] lin_addr;
  logic        canon_fault;
  logic [31:0] desc_base;
  logic [19:0] desc_limit;

  int n_cmp = 0, n_bad = 0;
  logic [63:0] m_wide [2];
  logic [31:0] m_dbase [6];
  logic [19:0] m_dlim [6];

  always #10 clk = ~clk;

  lm_linaddr_gen uut (.*);

  function automatic logic [63:0] exp_lin(logic [2:0] s, logic [63:0] o);
    if (s == 3'd4) return o + m_wide[0];
    if (s == 3'd5) return o + m_wide[1];
    return o;
  endfunction

  function automatic logic exp_fault(logic [63:0] a);
    logic [16:0] h = a[63:47];
    return !(h == 17'h0 || h == 17'h1ffff);
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) m_wide[i] = '0;
    for (int i = 0; i < 6; i++) begin m_dbase[i] = '0; m_dlim[i] = '0; end
  endtask

  task automatic step(string tag, logic [2:0] s, logic [63:0] o,
                      logic wf, logic wg, logic [63:0] wd,
                      logic le, logic [2:0] ls, logic [31:0] lb, logic [19:0] ll);
    logic [63:0] e;
    @(negedge clk);
    seg_sel = s; ofs = o; wr_fs = wf; wr_gs = wg; wr_data = wd;
    ld_en = le; ld_seg = ls; ld_base = lb; ld_limit = ll;
    #1;
    e = exp_lin(s, o);
    check(tag, lin_addr, e);
    check({tag, " R4 fault"}, {63'b0, canon_fault}, {63'b0, exp_fault(e)});
    check({tag, " R8 base"}, {32'b0, desc_base}, (s < 6) ? {32'b0, m_dbase[s]} : 64'b0);
    check({tag, " R8 limit"}, {44'b0, desc_limit}, (s < 6) ? {44'b0, m_dlim[s]} : 64'b0);
    @(posedge clk);
    if (le && ls < 6) begin m_dbase[ls] = lb; m_dlim[ls] = ll; end
    if (le && ls == 3'd4) m_wide[0] = {32'b0, lb}; else if (wf) m_wide[0] = wd;
    if (le && ls == 3'd5) m_wide[1] = {32'b0, lb}; else if (wg) m_wide[1] = wd;
  endtask

  function automatic logic [63:0] rnd_addr();
    logic [63:0] r = {$urandom, $urandom};
    case ($urandom % 4)
      0: return r;
      1: return {17'h0, r[46:0]};
      2: return {17'h1ffff, r[46:0]};
      default: return 64'h0000_7fff_ffff_fff0 + {60'b0, r[3:0]} + (r[4] ? 64'hffff_0000_0000_0000 : 64'h0);
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R9: everything cleared after reset
    step("R9 fs zero", 3'd4, 64'h1234, 0, 0, 0, 0, 0, 0, 0);
    step("R9 gs zero", 3'd5, 64'h5678, 0, 0, 0, 0, 0, 0, 0);
    // R1: flat segment ignores a loaded base
    step("R1 load ds", 3'd3, 64'h10, 0, 0, 0, 1, 3'd3, 32'hdead_b000, 20'h00fff);
    step("R1 ds flat", 3'd3, 64'h0000_1000_0000_0000, 0, 0, 0, 0, 0, 0, 0);
    // R3: offset above cached limit, no fault
    step("R3 no limit", 3'd3, 64'h0000_0000_ffff_0000, 0, 0, 0, 0, 0, 0, 0);
    // R4 boundaries on a flat segment
    step("R4 top low ok", 3'd0, 64'h0000_7fff_ffff_ffff, 0, 0, 0, 0, 0, 0, 0);
    step("R4 hole low", 3'd0, 64'h0000_8000_0000_0000, 0, 0, 0, 0, 0, 0, 0);
    step("R4 bottom hi ok", 3'd1, 64'hffff_8000_0000_0000, 0, 0, 0, 0, 0, 0, 0);
    step("R4 hole hi", 3'd2, 64'hffff_7fff_ffff_ffff, 0, 0, 0, 0, 0, 0, 0);
    // R5: descriptor load into fs, zero-extended
    step("R5 load fs", 3'd0, 64'h0, 0, 0, 0, 1, 3'd4, 32'h8000_0000, 20'h1);
    step("R5 fs base", 3'd4, 64'h100, 0, 0, 0, 0, 0, 0, 0);
    // R6: direct write to gs, then fault via carry into hole
    step("R6 write gs", 3'd0, 64'h0, 0, 1, 64'h0000_7fff_ffff_ff00, 0, 0, 0, 0);
    step("R6 gs sum", 3'd5, 64'h80, 0, 0, 0, 0, 0, 0, 0);
    step("R2 gs carry fault", 3'd5, 64'h100, 0, 0, 0, 0, 0, 0, 0);
    // R7: same-cycle load beats direct write
    step("R7 both fs", 3'd0, 64'h0, 1, 0, 64'hffff_ffff_0000_0000, 1, 3'd4, 32'h0000_4000, 20'h2);
    step("R7 fs result", 3'd4, 64'h4, 0, 0, 0, 0, 0, 0, 0);
    // R2: wrap modulo 2^64
    step("R2 write fs", 3'd0, 64'h0, 1, 0, 64'hffff_ffff_ffff_fff0, 0, 0, 0, 0);
    step("R2 fs wrap", 3'd4, 64'h20, 0, 0, 0, 0, 0, 0, 0);
    // R10: selectors 6,7 and an ignored load
    step("R10 load sel6", 3'd6, 64'h77, 0, 0, 0, 1, 3'd6, 32'hffff_ffff, 20'hfffff);
    step("R10 sel7", 3'd7, 64'hffff_ffff_ffff_ffff, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++)
      step("R10 cache intact", 3'(i), 64'h0, 0, 0, 0, 0, 0, 0, 0);
    // R8 across all segments
    for (int i = 0; i < 6; i++)
      step("R8 load", 3'(i), 64'h0, 0, 0, 0, 1, 3'(i), 32'h1000 * (i + 1), 20'(i + 7));
    for (int i = 0; i < 6; i++)
      step("R8 readback", 3'(i), 64'h40, 0, 0, 0, 0, 0, 0, 0);
    // random mix
    void'($urandom(32'd4242));
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] s = 3'($urandom % 8);
      string tg = (s < 4 || s > 5) ? "R1 rnd" : "R2 rnd";
      step(tg, s, rnd_addr(), ($urandom % 8) == 0, ($urandom % 8) == 0, rnd_addr(),
           ($urandom % 6) == 0, 3'($urandom % 8), $urandom, 20'($urandom));
    end
    // R9 again: reset mid-run clears loaded state
    @(negedge clk); rst = 1; ld_en = 0; wr_fs = 0; wr_gs = 0;
    @(posedge clk); model_reset();
    @(negedge clk); rst = 0;
    step("R9 after rerun fs", 3'd4, 64'h99, 0, 0, 0, 0, 0, 0, 0);
    step("R9 after rerun ds", 3'd3, 64'h99, 0, 0, 0, 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule